// File: doc/BRIEF.md
# Commit-Stage Instruction Result Checker

This block sits between a speculative processor core and architectural commit. The core hands over one instruction at a time, in program order. Each handover carries the core's claims: the program counter, the instruction word, both source operand values, the result (or the effective address), and the next program counter. The checker keeps its own architected register file and its own program counter. It fetches the instruction word at its own program counter through a read port, recomputes every claimed value from its own state, and compares each claim with its own value.

When all claims agree, the instruction commits with the core's values and the checker stays in check mode. When any claim disagrees, the checker commits its own recomputed values instead and records which claims failed. It then enters recovery mode. In recovery mode it stops accepting the prediction stream, asks the core to flush, and gives the corrected next PC as the restart point. It goes back to check mode once the core acknowledges the flush. A saturating counter records how many recoveries have happened.

Instruction word layout: bits [31:28] opcode, [27:24] rd, [23:20] rs1, [19:16] rs2, [15:0] signed immediate. A register index is taken from the low log2(NREGS) bits of its field.

Top module: `commit_checker`

## Requirements
- R1: After reset, pred_ready is 1, commit_valid and redirect_valid are 0, mismatch_cnt is 0 and imem_addr equals RESET_PC.
- R2: The register opcodes are ADD=0, SUB=1, AND=2, OR=3 and XOR=4, each computing rs1 op rs2. The immediate opcode is ADDI=5, computing rs1 + sign-extended imm. Each of these writes rd and has next PC = PC+4. Register 0 always reads as zero, even after it is written.
- R3: BEQ=6 and BNE=7 compare rs1 with rs2. If the branch is taken, next PC = PC + (sign-extended imm << 2); otherwise next PC = PC+4. The result is the taken flag (1 or 0), and no register is written.
- R4: LDA=8 and STA=9 produce the effective address rs1 + sign-extended imm as their result. They write no register and have next PC = PC+4.
- R5: An accepted instruction whose claims all match commits on the next cycle with the core's values. At that commit, commit_fixed is 0, commit_fault is 0 and the checker stays in check mode.
- R6: An accepted instruction with any mismatching claim commits on the next cycle with the checker's own values and commit_fixed = 1. commit_fault marks the failing claims: bit0 PC, bit1 instruction word, bit2 operand A, bit3 operand B, bit4 result, bit5 next PC.
- R7: In recovery mode, pred_ready is 0 and redirect_valid is 1, with redirect_pc equal to the corrected next PC. Both hold until flush_ack is seen, and offered instructions produce no commit.
- R8: flush_ack has no effect while the checker is in check mode.
- R9: mismatch_cnt increases by one on each commit with commit_fixed = 1 and saturates at its maximum value.
- R10: After a recovery, the register file and the PC hold the checker's corrected values, so later instructions that claim the corrected values match.
- R11: Any other opcode writes nothing, yields result 0 and has next PC = PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_valid | input | 1 | Core offers an instruction's claims |
| pred_ready | output | 1 | Checker accepts claims (check mode) |
| pred_pc | input | XLEN | Claimed PC |
| pred_inst | input | 32 | Claimed instruction word |
| pred_opa | input | XLEN | Claimed rs1 value |
| pred_opb | input | XLEN | Claimed rs2 value |
| pred_res | input | XLEN | Claimed result or address |
| pred_npc | input | XLEN | Claimed next PC |
| imem_addr | output | XLEN | Checker's own fetch address |
| imem_data | input | 32 | Instruction word at imem_addr (combinational read) |
| commit_valid | output | 1 | One-cycle commit pulse |
| commit_pc | output | XLEN | PC of committed instruction |
| commit_we | output | 1 | Committed instruction writes rd |
| commit_rd | output | 4 | Destination field |
| commit_data | output | XLEN | Committed result or address |
| commit_fixed | output | 1 | Commit used the checker's own values |
| commit_fault | output | 6 | Which claims mismatched |
| redirect_valid | output | 1 | Flush and restart request |
| redirect_pc | output | XLEN | Restart address |
| flush_ack | input | 1 | Core acknowledges the flush |
| mismatch_cnt | output | CNT_W | Saturating recovery count |

## Verification
The main function is exercised with several kinds of traffic. Clean streams of every opcode check that correct claims pass untouched. Each of the six claims is then corrupted alone, and commit_fault must name exactly that claim, which tells the claim comparators apart. Taken and not-taken branches in both polarities separate the two next-PC choices. An instruction that follows a corrupted result shows that the corrected value, and not the claim, reached the register file. Instructions offered during recovery and stray flush acknowledgements in check mode show that the mode gating ignores them.

// File: rtl/ckr_pkg.sv
// Shared types for the commit checker: instruction layout, opcodes and
// claim-fault bit positions. Assumes a fixed 32-bit instruction word.
package ckr_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_ADDI = 4'd5,
        OP_BEQ  = 4'd6,
        OP_BNE  = 4'd7,
        OP_LDA  = 4'd8,
        OP_STA  = 4'd9
    } opcode_e;

    typedef struct packed {
        logic [3:0]  op;
        logic [3:0]  rd;
        logic [3:0]  rs1;
        logic [3:0]  rs2;
        logic [15:0] imm;
    } inst_t;

    localparam int FAULT_W   = 6;
    localparam int FLT_PC    = 0;
    localparam int FLT_INST  = 1;
    localparam int FLT_OPA   = 2;
    localparam int FLT_OPB   = 3;
    localparam int FLT_RES   = 4;
    localparam int FLT_NPC   = 5;

    typedef enum logic {
        MODE_CHECK   = 1'b0,
        MODE_RECOVER = 1'b1
    } mode_e;

endpackage

// File: rtl/ckr_regfile.sv
// Architected register file of the checker. Two combinational read ports,
// one synchronous write port. Register 0 is hard-wired to zero.
// Assumes NREGS is a power of two of at least 2.
module ckr_regfile #(
    parameter int NREGS = 8,
    parameter int XLEN  = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra_idx,
    input  logic [AW-1:0]   rb_idx,
    output logic [XLEN-1:0] ra_data,
    output logic [XLEN-1:0] rb_data,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_data
);

    logic [XLEN-1:0] regs [NREGS];

    generate
        for (genvar g = 0; g < NREGS; g++) begin : g_reg
            if (g == 0) begin : g_zero
                // Register 0 holds constant zero.
                assign regs[g] = '0;
            end else begin : g_store
                logic [XLEN-1:0] q;
                // Store a written value; clear on reset.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        q <= '0;
                    end else if (wr_en && (wr_idx == AW'(g))) begin
                        q <= wr_data;
                    end
                end
                assign regs[g] = q;
            end
        end
    endgenerate

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];

endmodule

// File: rtl/ckr_exec.sv
// Independent recomputation of one instruction from the checker's own
// fetched word, own PC and own operand values. Purely combinational.
// Assumes 4-byte instruction spacing.
module ckr_exec
    import ckr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     inst_word,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] result,
    output logic [XLEN-1:0] npc,
    output logic            wr_en
);

    inst_t           ins;
    logic [XLEN-1:0] simm;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] tgt_pc;
    logic            taken;

    assign ins    = inst_t'(inst_word);
    assign simm   = {{(XLEN-16){ins.imm[15]}}, ins.imm};
    assign seq_pc = pc + XLEN'(4);
    assign tgt_pc = pc + (simm << 2);

    // Evaluate result, write enable and next PC per opcode.
    always_comb begin
        result = '0;
        wr_en  = 1'b0;
        taken  = 1'b0;
        case (ins.op)
            OP_ADD:  begin result = opa + opb;  wr_en = 1'b1; end
            OP_SUB:  begin result = opa - opb;  wr_en = 1'b1; end
            OP_AND:  begin result = opa & opb;  wr_en = 1'b1; end
            OP_OR:   begin result = opa | opb;  wr_en = 1'b1; end
            OP_XOR:  begin result = opa ^ opb;  wr_en = 1'b1; end
            OP_ADDI: begin result = opa + simm; wr_en = 1'b1; end
            OP_BEQ:  begin taken = (opa == opb); result = XLEN'(taken); end
            OP_BNE:  begin taken = (opa != opb); result = XLEN'(taken); end
            OP_LDA,
            OP_STA:  begin result = opa + simm; end
            default: begin result = '0; end
        endcase
        npc = taken ? tgt_pc : seq_pc;
    end

endmodule

// File: rtl/ckr_compare.sv
// Compares each of the core's claims with the checker's own value and
// reports one fault bit per claim. Purely combinational.
module ckr_compare
    import ckr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]    claim_pc,
    input  logic [31:0]        claim_inst,
    input  logic [XLEN-1:0]    claim_opa,
    input  logic [XLEN-1:0]    claim_opb,
    input  logic [XLEN-1:0]    claim_res,
    input  logic [XLEN-1:0]    claim_npc,
    input  logic [XLEN-1:0]    own_pc,
    input  logic [31:0]        own_inst,
    input  logic [XLEN-1:0]    own_opa,
    input  logic [XLEN-1:0]    own_opb,
    input  logic [XLEN-1:0]    own_res,
    input  logic [XLEN-1:0]    own_npc,
    output logic [FAULT_W-1:0] fault,
    output logic               any_fault
);

    // One inequality per claim, placed at its fixed bit position.
    always_comb begin
        fault           = '0;
        fault[FLT_PC]   = (claim_pc   != own_pc);
        fault[FLT_INST] = (claim_inst != own_inst);
        fault[FLT_OPA]  = (claim_opa  != own_opa);
        fault[FLT_OPB]  = (claim_opb  != own_opb);
        fault[FLT_RES]  = (claim_res  != own_res);
        fault[FLT_NPC]  = (claim_npc  != own_npc);
    end

    assign any_fault = |fault;

endmodule

// File: rtl/ckr_ctrl.sv
// Mode control: check mode accepts claims; a faulty accepted instruction
// moves to recovery, which holds until the core acknowledges the flush.
// Also keeps the saturating recovery counter.
module ckr_ctrl
    import ckr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             any_fault,
    input  logic             flush_ack,
    output logic             in_recovery,
    output logic [CNT_W-1:0] mismatch_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    mode_e mode_q;

    // Mode transitions between check and recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_CHECK;
        end else begin
            case (mode_q)
                MODE_CHECK:   if (accept && any_fault) mode_q <= MODE_RECOVER;
                MODE_RECOVER: if (flush_ack)           mode_q <= MODE_CHECK;
                default:                               mode_q <= MODE_CHECK;
            endcase
        end
    end

    // Count recoveries, holding at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mismatch_cnt <= '0;
        end else if (accept && any_fault && (mismatch_cnt != CNT_MAX)) begin
            mismatch_cnt <= mismatch_cnt + CNT_W'(1);
        end
    end

    assign in_recovery = (mode_q == MODE_RECOVER);

endmodule

// File: rtl/commit_checker.sv
// Top of the commit-stage checker. Takes in-order claims from a speculative
// core, recomputes them from its own PC, fetched word and register file,
// commits matching results, and on mismatch commits its own values and
// requests a flush and restart at the corrected next PC.
// Assumes a combinational instruction read port and single issue.
module commit_checker
    import ckr_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              NREGS    = 8,
    parameter int              CNT_W    = 16,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pred_valid,
    output logic               pred_ready,
    input  logic [XLEN-1:0]    pred_pc,
    input  logic [31:0]        pred_inst,
    input  logic [XLEN-1:0]    pred_opa,
    input  logic [XLEN-1:0]    pred_opb,
    input  logic [XLEN-1:0]    pred_res,
    input  logic [XLEN-1:0]    pred_npc,
    output logic [XLEN-1:0]    imem_addr,
    input  logic [31:0]        imem_data,
    output logic               commit_valid,
    output logic [XLEN-1:0]    commit_pc,
    output logic               commit_we,
    output logic [3:0]         commit_rd,
    output logic [XLEN-1:0]    commit_data,
    output logic               commit_fixed,
    output logic [FAULT_W-1:0] commit_fault,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    input  logic               flush_ack,
    output logic [CNT_W-1:0]   mismatch_cnt
);

    localparam int AW = $clog2(NREGS);

    logic [XLEN-1:0]    arch_pc;
    inst_t              own_ins;
    logic [XLEN-1:0]    own_opa;
    logic [XLEN-1:0]    own_opb;
    logic [XLEN-1:0]    own_res;
    logic [XLEN-1:0]    own_npc;
    logic               own_we;
    logic [FAULT_W-1:0] fault;
    logic               any_fault;
    logic               in_recovery;
    logic               accept;

    assign own_ins    = inst_t'(imem_data);
    assign imem_addr  = arch_pc;
    assign pred_ready = !in_recovery;
    assign accept     = pred_valid && pred_ready;

    ckr_regfile #(.NREGS(NREGS), .XLEN(XLEN)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (own_ins.rs1[AW-1:0]),
        .rb_idx  (own_ins.rs2[AW-1:0]),
        .ra_data (own_opa),
        .rb_data (own_opb),
        .wr_en   (accept && own_we),
        .wr_idx  (own_ins.rd[AW-1:0]),
        .wr_data (own_res)
    );

    ckr_exec #(.XLEN(XLEN)) u_exec (
        .inst_word (imem_data),
        .pc        (arch_pc),
        .opa       (own_opa),
        .opb       (own_opb),
        .result    (own_res),
        .npc       (own_npc),
        .wr_en     (own_we)
    );

    ckr_compare #(.XLEN(XLEN)) u_cmp (
        .claim_pc   (pred_pc),
        .claim_inst (pred_inst),
        .claim_opa  (pred_opa),
        .claim_opb  (pred_opb),
        .claim_res  (pred_res),
        .claim_npc  (pred_npc),
        .own_pc     (arch_pc),
        .own_inst   (imem_data),
        .own_opa    (own_opa),
        .own_opb    (own_opb),
        .own_res    (own_res),
        .own_npc    (own_npc),
        .fault      (fault),
        .any_fault  (any_fault)
    );

    ckr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .any_fault    (any_fault),
        .flush_ack    (flush_ack),
        .in_recovery  (in_recovery),
        .mismatch_cnt (mismatch_cnt)
    );

    // Architected PC advances to the checker's own next PC on each accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arch_pc <= RESET_PC;
        end else if (accept) begin
            arch_pc <= own_npc;
        end
    end

    // Register the commit: the core's result when clean, the checker's own otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_valid <= 1'b0;
            commit_pc    <= '0;
            commit_we    <= 1'b0;
            commit_rd    <= '0;
            commit_data  <= '0;
            commit_fixed <= 1'b0;
            commit_fault <= '0;
        end else begin
            commit_valid <= accept;
            if (accept) begin
                commit_pc    <= arch_pc;
                commit_we    <= own_we;
                commit_rd    <= own_ins.rd;
                commit_data  <= any_fault ? own_res : pred_res;
                commit_fixed <= any_fault;
                commit_fault <= fault;
            end
        end
    end

    assign redirect_valid = in_recovery;
    assign redirect_pc    = arch_pc;

endmodule

// File: rtl/ckr_sva.sv
// Protocol and mode properties of the commit checker, bound to the top.
module ckr_sva
    import ckr_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pred_valid,
    input logic               pred_ready,
    input logic               commit_valid,
    input logic               commit_fixed,
    input logic [FAULT_W-1:0] commit_fault,
    input logic               redirect_valid,
    input logic [XLEN-1:0]    redirect_pc,
    input logic               flush_ack,
    input logic [CNT_W-1:0]   mismatch_cnt
);

    p_commit_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && pred_ready) |=> commit_valid);

    p_no_commit_without_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pred_valid && pred_ready) |=> !commit_valid);

    p_clean_stays_check_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && !commit_fixed) |-> (pred_ready && commit_fault == '0));

    p_fixed_enters_recovery_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && commit_fixed) |-> (redirect_valid && commit_fault != '0));

    p_ready_low_in_recovery_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> !pred_ready);

    p_redirect_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && !flush_ack) |=> (redirect_valid && $stable(redirect_pc)));

    p_ack_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && flush_ack) |=> pred_ready);

    p_stray_ack_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_ready && flush_ack && !pred_valid) |=> pred_ready);

    p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && pred_ready && mismatch_cnt != {CNT_W{1'b1}})
        |=> (mismatch_cnt == $past(mismatch_cnt) + CNT_W'(commit_fixed)));

    p_cnt_saturates_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch_cnt == {CNT_W{1'b1}}) |=> (mismatch_cnt == {CNT_W{1'b1}}));

endmodule

bind commit_checker ckr_sva #(.XLEN(XLEN), .CNT_W(CNT_W)) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .pred_valid     (pred_valid),
    .pred_ready     (pred_ready),
    .commit_valid   (commit_valid),
    .commit_fixed   (commit_fixed),
    .commit_fault   (commit_fault),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .flush_ack      (flush_ack),
    .mismatch_cnt   (mismatch_cnt)
);

// File: tb/sim_commit_checker.sv
// Scoreboard bench: the driver computes expected commits from a reference
// model of the requirements and queues them; a monitor compares commits.
module sim_commit_checker;

    localparam int XLEN  = 32;
    localparam int CNT_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pred_valid = 1'b0;
    logic              pred_ready;
    logic [XLEN-1:0]   pred_pc = '0, pred_opa = '0, pred_opb = '0;
    logic [XLEN-1:0]   pred_res = '0, pred_npc = '0;
    logic [31:0]       pred_inst = '0;
    logic [XLEN-1:0]   imem_addr;
    logic [31:0]       imem_data;
    logic              commit_valid, commit_we, commit_fixed;
    logic [XLEN-1:0]   commit_pc, commit_data;
    logic [3:0]        commit_rd;
    logic [5:0]        commit_fault;
    logic              redirect_valid;
    logic [XLEN-1:0]   redirect_pc;
    logic              flush_ack = 1'b0;
    logic [CNT_W-1:0]  mismatch_cnt;

    logic [31:0] mem [64];
    assign imem_data = mem[imem_addr[7:2]];

    always #4 clk = ~clk;   // 125 MHz

    commit_checker #(.XLEN(XLEN), .NREGS(8), .CNT_W(CNT_W), .RESET_PC('0)) u0 (
        .clk(clk), .rst_n(rst_n),
        .pred_valid(pred_valid), .pred_ready(pred_ready),
        .pred_pc(pred_pc), .pred_inst(pred_inst), .pred_opa(pred_opa),
        .pred_opb(pred_opb), .pred_res(pred_res), .pred_npc(pred_npc),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .commit_valid(commit_valid), .commit_pc(commit_pc), .commit_we(commit_we),
        .commit_rd(commit_rd), .commit_data(commit_data),
        .commit_fixed(commit_fixed), .commit_fault(commit_fault),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .flush_ack(flush_ack), .mismatch_cnt(mismatch_cnt)
    );

    typedef struct {
        logic [XLEN-1:0] pc;
        logic            we;
        logic [3:0]      rd;
        logic [XLEN-1:0] data;
        logic            fixed;
        logic [5:0]      fault;
        logic [CNT_W-1:0] cnt;
        string           req;
    } exp_t;

    exp_t            sb[$];
    int              n_chk = 0;
    int              n_bad = 0;
    logic [XLEN-1:0] m_reg [8];
    logic [XLEN-1:0] m_pc = '0;
    int              m_cnt = 0;
    int              cycles = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [31:0] enc(input int op, input int rd, input int rs1,
                                        input int rs2, input int imm);
        return {op[3:0], rd[3:0], rs1[3:0], rs2[3:0], imm[15:0]};
    endfunction

    // Reference model from the requirements: values a correct core claims.
    task automatic model(input logic [31:0] ins, output logic [XLEN-1:0] a,
                         output logic [XLEN-1:0] b, output logic [XLEN-1:0] res,
                         output logic [XLEN-1:0] npc, output logic we);
        logic [XLEN-1:0] si;
        si  = {{16{ins[15]}}, ins[15:0]};
        a   = m_reg[ins[22:20]];
        b   = m_reg[ins[18:16]];
        we  = 1'b0;
        res = '0;
        npc = m_pc + 4;
        case (ins[31:28])
            4'd0: begin res = a + b; we = 1'b1; end
            4'd1: begin res = a - b; we = 1'b1; end
            4'd2: begin res = a & b; we = 1'b1; end
            4'd3: begin res = a | b; we = 1'b1; end
            4'd4: begin res = a ^ b; we = 1'b1; end
            4'd5: begin res = a + si; we = 1'b1; end
            4'd6: begin res = (a == b) ? 1 : 0; if (a == b) npc = m_pc + (si << 2); end
            4'd7: begin res = (a != b) ? 1 : 0; if (a != b) npc = m_pc + (si << 2); end
            4'd8, 4'd9: res = a + si;
            default: res = '0;
        endcase
    endtask

    // Drive one instruction; mask selects corrupted claims (bit order as commit_fault).
    task automatic send(input logic [31:0] ins, input logic [5:0] mask, input string req);
        logic [XLEN-1:0] a, b, res, npc;
        logic            we;
        exp_t            e;
        model(ins, a, b, res, npc, we);
        mem[m_pc[7:2]] = ins;
        while (!pred_ready) @(negedge clk);
        pred_valid = 1'b1;
        pred_pc    = m_pc ^ (mask[0] ? 32'h40 : 32'h0);
        pred_inst  = ins  ^ (mask[1] ? 32'h100 : 32'h0);
        pred_opa   = a    ^ (mask[2] ? 32'h1 : 32'h0);
        pred_opb   = b    ^ (mask[3] ? 32'h2 : 32'h0);
        pred_res   = res  ^ (mask[4] ? 32'h10 : 32'h0);
        pred_npc   = npc  ^ (mask[5] ? 32'h4 : 32'h0);
        if (mask != 0 && m_cnt < 3) m_cnt++;
        e.pc = m_pc; e.we = we; e.rd = ins[27:24]; e.data = res;
        e.fixed = (mask != 0); e.fault = mask; e.cnt = CNT_W'(m_cnt); e.req = req;
        sb.push_back(e);
        if (we && ins[26:24] != 0) m_reg[ins[26:24]] = res;
        m_pc = npc;
        @(negedge clk);
        pred_valid = 1'b0;
        if (mask != 0) begin
            check(redirect_valid === 1'b1, "R7", "redirect_valid", XLEN'(redirect_valid), 1);
            check(redirect_pc === npc, "R7", "redirect_pc", redirect_pc, npc);
            check(pred_ready === 1'b0, "R7", "pred_ready in recovery", XLEN'(pred_ready), 0);
            pred_valid = 1'b1;   // offers during recovery must be ignored
            repeat (2) @(negedge clk);
            check(redirect_pc === npc, "R7", "redirect_pc held", redirect_pc, npc);
            pred_valid = 1'b0;
            flush_ack  = 1'b1;
            @(negedge clk);
            flush_ack  = 1'b0;
            check(pred_ready === 1'b1, "R7", "ready after ack", XLEN'(pred_ready), 1);
            check(redirect_valid === 1'b0, "R7", "redirect cleared", XLEN'(redirect_valid), 0);
        end
    endtask

    // Monitor: compare every commit against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && commit_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7", "unexpected commit", commit_pc, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(commit_pc === e.pc, e.req, "commit_pc", commit_pc, e.pc);
                check(commit_we === e.we, e.req, "commit_we", XLEN'(commit_we), XLEN'(e.we));
                check(commit_rd === e.rd, e.req, "commit_rd", XLEN'(commit_rd), XLEN'(e.rd));
                check(commit_data === e.data, e.req, "commit_data", commit_data, e.data);
                check(commit_fixed === e.fixed, e.req, "commit_fixed",
                      XLEN'(commit_fixed), XLEN'(e.fixed));
                check(commit_fault === e.fault, e.req, "commit_fault",
                      XLEN'(commit_fault), XLEN'(e.fault));
                check(mismatch_cnt === e.cnt, "R9", "mismatch_cnt",
                      XLEN'(mismatch_cnt), XLEN'(e.cnt));
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            check(1'b0, "R1", "watchdog expired", XLEN'(cycles), 0);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(pred_ready === 1'b1, "R1", "pred_ready", XLEN'(pred_ready), 1);
        check(commit_valid === 1'b0, "R1", "commit_valid", XLEN'(commit_valid), 0);
        check(redirect_valid === 1'b0, "R1", "redirect_valid", XLEN'(redirect_valid), 0);
        check(mismatch_cnt === '0, "R1", "mismatch_cnt", XLEN'(mismatch_cnt), 0);
        check(imem_addr === '0, "R1", "imem_addr", imem_addr, 0);

        // R2: ALU and immediate ops, register 0 stays zero
        send(enc(5, 1, 0, 0, 5), 0, "R2");
        send(enc(5, 2, 0, 0, -3), 0, "R2");
        send(enc(0, 3, 1, 2, 0), 0, "R2");
        send(enc(1, 4, 1, 2, 0), 0, "R2");
        send(enc(2, 5, 1, 2, 0), 0, "R2");
        send(enc(3, 6, 1, 2, 0), 0, "R2");
        send(enc(4, 7, 1, 2, 0), 0, "R2");
        send(enc(0, 0, 1, 1, 0), 0, "R2");
        send(enc(0, 3, 0, 1, 0), 0, "R2");

        // R3: branches taken and not taken, forward and backward
        send(enc(6, 0, 1, 1, 3), 0, "R3");
        send(enc(6, 0, 1, 2, 3), 0, "R3");
        send(enc(7, 0, 1, 2, -2), 0, "R3");
        send(enc(7, 0, 1, 1, 5), 0, "R3");
        send(enc(6, 0, 0, 0, 4), 0, "R3");

        // R4: address generation
        send(enc(8, 3, 1, 0, 100), 0, "R4");
        send(enc(9, 3, 2, 4, -8), 0, "R4");

        // R11: undefined opcode
        send(enc(15, 4, 1, 2, 7), 0, "R11");

        // R8: stray flush_ack in check mode
        @(negedge clk);
        flush_ack = 1'b1;
        @(negedge clk);
        flush_ack = 1'b0;
        check(pred_ready === 1'b1, "R8", "pred_ready", XLEN'(pred_ready), 1);
        check(redirect_valid === 1'b0, "R8", "redirect_valid", XLEN'(redirect_valid), 0);
        send(enc(0, 5, 1, 1, 0), 0, "R8");

        // R6: each claim corrupted alone; R9 counts and saturates
        send(enc(0, 6, 1, 2, 0), 6'b000001, "R6");
        send(enc(0, 6, 1, 2, 0), 6'b000010, "R6");
        send(enc(1, 6, 2, 1, 0), 6'b000100, "R6");
        send(enc(3, 6, 1, 2, 0), 6'b001000, "R6");
        send(enc(6, 0, 1, 1, 2), 6'b100000, "R6");
        send(enc(0, 3, 1, 1, 0), 6'b010000, "R6");
        // R10: corrected value of r3 (10) is used next
        send(enc(0, 7, 3, 1, 0), 0, "R10");
        send(enc(6, 0, 3, 7, 2), 6'b110011, "R6");
        send(enc(4, 2, 7, 3, 0), 0, "R10");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R5", "commits outstanding", XLEN'(sb.size()), 0);
        finish_run();
    end

endmodule